// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block watches the access strobes of an SRAM port (address, active-low chip enable, output enable and write enable) in a synchronous clock domain. It looks for an unlock pattern of six back-to-back reads. The first five reads come from fixed addresses. The sixth read selects one of four nonvolatile commands: save the array (STORE), reload the array (RECALL), turn automatic power-down saving off, or turn it back on. When the pattern completes, the block sends the store/recall controller a one-cycle command strobe together with a two-bit command code.

A STORE or RECALL also makes the block raise a float request. This request puts the data pins into high impedance and locks out further access until the controller reports that the nonvolatile cycle is finished. Any write, or any read from an address that is not the expected next one, cancels the pattern. The block ignores all accesses while the controller reports busy.

Top module: `nv_read_seq_detect`

## Requirements
- R1: After the five unlock reads (0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order), a sixth read from 0x0FC0 issues code 0 (STORE) and a sixth read from 0x0C63 issues code 1 (RECALL).
- R2: For the five unlock reads and for the STORE and RECALL selectors, address bits 1:0 are ignored. Only bits 14:2 are compared.
- R3: A sixth read with bits 14:2 equal to those of 0x0B44 issues code 2 (auto-save off) when bits 1:0 are 01, and code 3 (auto-save on) when bits 1:0 are 10. When bits 1:0 are 00 or 11, no command is issued.
- R4: A read is an access with chip enable low, output enable low and write enable high. It counts once, on the first sampled cycle after either chip enable or output enable returns high, no matter how many cycles the read was held.
- R5: A cycle with chip enable and write enable both low cancels a partial pattern, so no command follows from the reads made before it.
- R6: A counted read from an unexpected address cancels the pattern. If that read's bits 14:2 match the first unlock address, the pattern restarts with the second unlock read expected next.
- R7: The command strobe is high for exactly one cycle: the cycle after the clock edge that first samples the sixth read as released. The command code is valid while the strobe is high.
- R8: The float request rises together with a STORE or RECALL strobe and stays high until the cycle-done input is seen. Auto-save on/off commands do not raise it.
- R9: While busy is high or the float request is high, reads and writes are ignored. Busy does not disturb a partial pattern that is already under way.
- R10: A cycle-done pulse clears the float request and returns the detector to idle, so a partial pattern does not survive it.
- R11: Out of reset, the strobe, the float request and the command code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | input | 15 | Access address |
| mem_ce_n | input | 1 | Chip enable, active low |
| mem_oe_n | input | 1 | Output enable, active low |
| mem_we_n | input | 1 | Write enable, active low |
| ctl_busy | input | 1 | Controller busy or inhibit; accesses ignored |
| ctl_done | input | 1 | Nonvolatile cycle finished |
| cmd_fire | output | 1 | One-cycle command strobe |
| cmd_kind | output | 2 | Command code (0 STORE, 1 RECALL, 2 auto-save off, 3 auto-save on) |
| dq_float | output | 1 | Float data pins and lock out access |

## Verification
Each read in the bench holds its enables low across at least one rising edge and then releases them. The edge that first samples the release registers the strobe, the code and the float request. The bench therefore checks those outputs at the falling edge right after the release cycle, and checks again one cycle later to confirm the strobe has dropped while the float request holds. A cycle-done pulse takes effect at the next edge, so the float request is checked low at the falling edge that ends the pulse. Wherever the expected result is that no command is issued, the strobe is sampled at those same falling edges.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  localparam int SEQ_ADDR_W = 15;
  localparam int SEQ_IGN_LSB = 2;
  localparam int SEQ_PRE_N = 5;

  typedef enum logic [1:0] {
    NVC_STORE  = 2'd0,
    NVC_RECALL = 2'd1,
    NVC_AS_OFF = 2'd2,
    NVC_AS_ON  = 2'd3
  } nv_cmd_e;

  function automatic logic [SEQ_ADDR_W-1:0] unlock_key(input int idx);
    case (idx)
      0:       unlock_key = 15'h0E38;
      1:       unlock_key = 15'h31C7;
      2:       unlock_key = 15'h03E0;
      3:       unlock_key = 15'h3C1F;
      default: unlock_key = 15'h303F;
    endcase
  endfunction

  localparam logic [SEQ_ADDR_W-1:0] SEL_STORE  = 15'h0FC0;
  localparam logic [SEQ_ADDR_W-1:0] SEL_RECALL = 15'h0C63;
  localparam logic [SEQ_ADDR_W-1:0] SEL_ASAVE  = 15'h0B44;

endpackage

// File: rtl/seq_strobe_sample.sv
module seq_strobe_sample #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ignore,
  output logic              rd_done,
  output logic              wr_seen,
  output logic [ADDR_W-1:0] rd_addr
);

  logic              rd_act;
  logic              wr_act;
  logic              rd_act_q;
  logic [ADDR_W-1:0] addr_q;

  assign rd_act = !ce_n && !oe_n && we_n;
  assign wr_act = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      rd_act_q <= rd_act;
      if (rd_act) begin
        addr_q <= addr;
      end
    end
  end

  assign rd_done = rd_act_q && !rd_act && !wr_act && !ignore;
  assign wr_seen = wr_act && !ignore;
  assign rd_addr = addr_q;

endmodule

// File: rtl/seq_key_match.sv
module seq_key_match
  import nvseq_pkg::*;
#(
  parameter int ADDR_W  = SEQ_ADDR_W,
  parameter int IGN_LSB = SEQ_IGN_LSB,
  parameter int PRE_N   = SEQ_PRE_N,
  localparam int STEP_W = $clog2(PRE_N + 1)
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_step,
  output logic              hit_first,
  output logic              fin_valid,
  output nv_cmd_e           fin_code
);

  logic [PRE_N-1:0]          pre_hit;
  logic [ADDR_W-1:IGN_LSB]   hi;
  logic [IGN_LSB-1:0]        lo;

  assign hi = addr[ADDR_W-1:IGN_LSB];
  assign lo = addr[IGN_LSB-1:0];

  for (genvar g = 0; g < PRE_N; g++) begin : g_pre
    localparam logic [ADDR_W-1:0] KEY = unlock_key(g);
    assign pre_hit[g] = (hi == KEY[ADDR_W-1:IGN_LSB]);
  end

  assign hit_first = pre_hit[0];

  always_comb begin
    hit_step = 1'b0;
    for (int i = 0; i < PRE_N; i++) begin
      if (step == STEP_W'(i)) begin
        hit_step = pre_hit[i];
      end
    end
  end

  always_comb begin
    fin_valid = 1'b0;
    fin_code  = NVC_STORE;
    if (hi == SEL_STORE[ADDR_W-1:IGN_LSB]) begin
      fin_valid = 1'b1;
      fin_code  = NVC_STORE;
    end else if (hi == SEL_RECALL[ADDR_W-1:IGN_LSB]) begin
      fin_valid = 1'b1;
      fin_code  = NVC_RECALL;
    end else if (hi == SEL_ASAVE[ADDR_W-1:IGN_LSB]) begin
      if (lo == IGN_LSB'(1)) begin
        fin_valid = 1'b1;
        fin_code  = NVC_AS_OFF;
      end else if (lo == IGN_LSB'(2)) begin
        fin_valid = 1'b1;
        fin_code  = NVC_AS_ON;
      end
    end
  end

endmodule

// File: rtl/seq_step_fsm.sv
module seq_step_fsm
  import nvseq_pkg::*;
#(
  parameter int PRE_N = SEQ_PRE_N,
  localparam int STEP_W = $clog2(PRE_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done,
  input  logic              wr_seen,
  input  logic              hit_step,
  input  logic              hit_first,
  input  logic              fin_valid,
  input  nv_cmd_e           fin_code,
  input  logic              done,
  output logic [STEP_W-1:0] step,
  output logic              fire,
  output nv_cmd_e           kind,
  output logic              lock
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(PRE_N);

  logic [STEP_W-1:0] step_n;
  logic              fire_n;
  nv_cmd_e           kind_n;
  logic              lock_n;
  logic [STEP_W-1:0] restart;

  assign restart = hit_first ? STEP_W'(1) : '0;

  always_comb begin
    step_n = step;
    fire_n = 1'b0;
    kind_n = kind;
    lock_n = lock;
    if (done) begin
      step_n = '0;
      lock_n = 1'b0;
    end else if (!lock) begin
      if (wr_seen) begin
        step_n = '0;
      end else if (rd_done) begin
        if (step == LAST) begin
          if (fin_valid) begin
            fire_n = 1'b1;
            kind_n = fin_code;
            step_n = '0;
            lock_n = (fin_code == NVC_STORE) || (fin_code == NVC_RECALL);
          end else begin
            step_n = restart;
          end
        end else if (hit_step) begin
          step_n = step + STEP_W'(1);
        end else begin
          step_n = restart;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      fire <= 1'b0;
      kind <= NVC_STORE;
      lock <= 1'b0;
    end else begin
      step <= step_n;
      fire <= fire_n;
      kind <= kind_n;
      lock <= lock_n;
    end
  end

endmodule

// File: rtl/nv_read_seq_detect.sv
module nv_read_seq_detect
  import nvseq_pkg::*;
#(
  parameter int ADDR_W  = SEQ_ADDR_W,
  parameter int IGN_LSB = SEQ_IGN_LSB,
  parameter int PRE_N   = SEQ_PRE_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ce_n,
  input  logic              mem_oe_n,
  input  logic              mem_we_n,
  input  logic              ctl_busy,
  input  logic              ctl_done,
  output logic              cmd_fire,
  output logic [1:0]        cmd_kind,
  output logic              dq_float
);

  localparam int STEP_W = $clog2(PRE_N + 1);

  logic              rd_done;
  logic              wr_seen;
  logic [ADDR_W-1:0] rd_addr;
  logic [STEP_W-1:0] step;
  logic              hit_step;
  logic              hit_first;
  logic              fin_valid;
  nv_cmd_e           fin_code;
  nv_cmd_e           kind;
  logic              lock;

  seq_strobe_sample #(.ADDR_W(ADDR_W)) u_sample (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (mem_addr),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .ignore  (ctl_busy || lock),
    .rd_done (rd_done),
    .wr_seen (wr_seen),
    .rd_addr (rd_addr)
  );

  seq_key_match #(.ADDR_W(ADDR_W), .IGN_LSB(IGN_LSB), .PRE_N(PRE_N)) u_match (
    .step      (step),
    .addr      (rd_addr),
    .hit_step  (hit_step),
    .hit_first (hit_first),
    .fin_valid (fin_valid),
    .fin_code  (fin_code)
  );

  seq_step_fsm #(.PRE_N(PRE_N)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_done   (rd_done),
    .wr_seen   (wr_seen),
    .hit_step  (hit_step),
    .hit_first (hit_first),
    .fin_valid (fin_valid),
    .fin_code  (fin_code),
    .done      (ctl_done),
    .step      (step),
    .fire      (cmd_fire),
    .kind      (kind),
    .lock      (lock)
  );

  assign cmd_kind = kind;
  assign dq_float = lock;

endmodule

// File: rtl/nv_read_seq_detect_check.sv
module nv_read_seq_detect_check (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       ctl_busy,
  input logic       ctl_done,
  input logic       cmd_fire,
  input logic [1:0] cmd_kind,
  input logic       dq_float
);

  AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_fire); // R7

  AST_NO_FIRE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> !$past(!mem_ce_n && !mem_we_n)); // R5

  AST_NO_FIRE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> !$past(ctl_busy)); // R9

  AST_FLOAT_WITH_NV: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> (dq_float == !cmd_kind[1])); // R8

  AST_FLOAT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_float) |-> cmd_fire); // R8

  AST_FLOAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dq_float && !ctl_done |=> dq_float); // R8

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_done |=> !dq_float && !cmd_fire); // R10

endmodule

bind nv_read_seq_detect nv_read_seq_detect_check u_check (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .ctl_busy (ctl_busy),
  .ctl_done (ctl_done),
  .cmd_fire (cmd_fire),
  .cmd_kind (cmd_kind),
  .dq_float (dq_float)
);

// File: tb/nv_read_seq_detect_bench.sv
`timescale 1ns/1ps
module nv_read_seq_detect_bench;

  logic        clk;
  logic        rst_n;
  logic [14:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic        ctl_busy;
  logic        ctl_done;
  logic        cmd_fire;
  logic [1:0]  cmd_kind;
  logic        dq_float;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [14:0] pre [5] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};

  nv_read_seq_detect u_nv_read_seq_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .ctl_busy (ctl_busy),
    .ctl_done (ctl_done),
    .cmd_fire (cmd_fire),
    .cmd_kind (cmd_kind),
    .dq_float (dq_float)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [14:0] a, input bit by_oe, input int hold);
    mem_addr = a; mem_ce_n = 1'b0; mem_oe_n = 1'b0; mem_we_n = 1'b1;
    repeat (hold) @(negedge clk);
    if (by_oe) mem_oe_n = 1'b1; else mem_ce_n = 1'b1;
    @(negedge clk);
    mem_ce_n = 1'b1; mem_oe_n = 1'b1;
  endtask

  task automatic wr(input logic [14:0] a);
    mem_addr = a; mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_oe_n = 1'b1;
    @(negedge clk);
    mem_ce_n = 1'b1; mem_we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prefix(input bit by_oe, input logic [1:0] lx);
    for (int i = 0; i < 5; i++) rd(pre[i] ^ {13'd0, lx}, by_oe, 1);
  endtask

  task automatic done_pulse();
    ctl_done = 1'b1;
    @(negedge clk);
    ctl_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "fire after reset", cmd_fire, 0);
    chk("R11", "float after reset", dq_float, 0);
    chk("R11", "kind after reset", cmd_kind, 0);
  endtask

  task automatic t_store_ce();
    prefix(1'b0, 2'b00);
    rd(15'h0FC0, 1'b0, 1);
    chk("R1", "store fire", cmd_fire, 1);
    chk("R1", "store kind", cmd_kind, 0);
    chk("R8", "store float", dq_float, 1);
    @(negedge clk);
    chk("R7", "store fire drops", cmd_fire, 0);
    chk("R8", "float holds", dq_float, 1);
    prefix(1'b0, 2'b00);
    rd(15'h0C63, 1'b0, 1);
    chk("R9", "locked sequence fire", cmd_fire, 0);
    chk("R9", "locked kind kept", cmd_kind, 0);
    done_pulse();
    chk("R10", "done clears float", dq_float, 0);
  endtask

  task automatic t_recall_oe();
    prefix(1'b1, 2'b11);
    rd(15'h0C60, 1'b1, 1);
    chk("R2", "recall fire low bits ignored", cmd_fire, 1);
    chk("R1", "recall kind", cmd_kind, 1);
    chk("R8", "recall float", dq_float, 1);
    done_pulse();
    chk("R10", "float cleared", dq_float, 0);
  endtask

  task automatic t_autosave();
    prefix(1'b0, 2'b01);
    rd(15'h0B45, 1'b0, 1);
    chk("R3", "as-off fire", cmd_fire, 1);
    chk("R3", "as-off kind", cmd_kind, 2);
    chk("R8", "as-off no float", dq_float, 0);
    prefix(1'b1, 2'b10);
    rd(15'h0B46, 1'b1, 1);
    chk("R3", "as-on fire", cmd_fire, 1);
    chk("R3", "as-on kind", cmd_kind, 3);
    chk("R8", "as-on no float", dq_float, 0);
    prefix(1'b0, 2'b00);
    rd(15'h0B44, 1'b0, 1);
    chk("R3", "low bits 00 no fire", cmd_fire, 0);
    prefix(1'b0, 2'b00);
    rd(15'h0B47, 1'b0, 1);
    chk("R3", "low bits 11 no fire", cmd_fire, 0);
  endtask

  task automatic t_held();
    int early = 0;
    rd(pre[0], 1'b0, 1);
    rd(pre[1], 1'b1, 4);
    for (int i = 2; i < 5; i++) rd(pre[i], 1'b0, 1);
    mem_addr = 15'h0B45; mem_ce_n = 1'b0; mem_oe_n = 1'b0; mem_we_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (cmd_fire) early++;
    end
    chk("R4", "no fire while held", early, 0);
    mem_ce_n = 1'b1;
    @(negedge clk);
    mem_oe_n = 1'b1;
    chk("R4", "held read counted once", cmd_fire, 1);
    @(negedge clk);
    chk("R7", "single pulse", cmd_fire, 0);
  endtask

  task automatic t_write_abort();
    for (int i = 0; i < 3; i++) rd(pre[i], 1'b0, 1);
    wr(pre[3]);
    rd(pre[3], 1'b0, 1);
    rd(pre[4], 1'b0, 1);
    rd(15'h0B46, 1'b0, 1);
    chk("R5", "write aborts", cmd_fire, 0);
    prefix(1'b0, 2'b00);
    rd(15'h0B46, 1'b0, 1);
    chk("R5", "clean sequence after abort", cmd_fire, 1);
  endtask

  task automatic t_wrong_addr();
    rd(pre[0], 1'b0, 1);
    rd(pre[1], 1'b0, 1);
    rd(15'h1234, 1'b0, 1);
    for (int i = 2; i < 5; i++) rd(pre[i], 1'b0, 1);
    rd(15'h0B45, 1'b0, 1);
    chk("R6", "stray read aborts", cmd_fire, 0);
    for (int i = 0; i < 3; i++) rd(pre[i], 1'b0, 1);
    prefix(1'b0, 2'b00);
    rd(15'h0B45, 1'b0, 1);
    chk("R6", "first address restarts", cmd_fire, 1);
    prefix(1'b0, 2'b00);
    rd(15'h1234, 1'b0, 1);
    chk("R6", "bad selector no fire", cmd_fire, 0);
  endtask

  task automatic t_busy();
    for (int i = 0; i < 3; i++) rd(pre[i], 1'b0, 1);
    ctl_busy = 1'b1;
    wr(15'h0000);
    rd(15'h1234, 1'b0, 1);
    ctl_busy = 1'b0;
    rd(pre[3], 1'b0, 1);
    rd(pre[4], 1'b0, 1);
    ctl_busy = 1'b1;
    rd(15'h0B46, 1'b0, 1);
    chk("R9", "busy final read ignored", cmd_fire, 0);
    ctl_busy = 1'b0;
    rd(15'h0B46, 1'b0, 1);
    chk("R9", "state kept across busy", cmd_fire, 1);
    chk("R9", "kind after busy", cmd_kind, 3);
  endtask

  task automatic t_done_clears();
    for (int i = 0; i < 3; i++) rd(pre[i], 1'b0, 1);
    done_pulse();
    rd(pre[3], 1'b0, 1);
    rd(pre[4], 1'b0, 1);
    rd(15'h0B45, 1'b0, 1);
    chk("R10", "done drops partial", cmd_fire, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mem_addr = '0; mem_ce_n = 1'b1; mem_oe_n = 1'b1; mem_we_n = 1'b1;
    ctl_busy = 1'b0; ctl_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_ce();
    t_recall_oe();
    t_autosave();
    t_held();
    t_write_abort();
    t_wrong_addr();
    t_busy();
    t_done_clears();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule